// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block connects a peripheral to a host processor bus that can run in one of two ways. In strobe mode the host drives separate active-low read and write strobes with no clock. The block answers on an open ready line `bus_rdy`, which it pulls low as soon as a strobe falls and releases only after the internal side has finished the transfer. In clocked mode the bus clock is also the block clock. The host marks the start of a cycle with a one-clock start strobe, and the block ends the cycle with a one-clock active-low done pulse.

In both modes the address is held by a capture stage that is transparent while the address strobe is low and holds its value from the rising edge of that strobe. A decoded access becomes a one-clock register read or write strobe on the internal side. A separate DMA select input skips the address decode and sends 32-bit transfers to a buffer-memory port. That port is addressed by an internal word pointer. The pointer steps by four bytes after each completed transfer and can be loaded and read back at one reserved register address.

The internal registers and the memory are outside the block. The internal side reports that a transfer is finished with `int_done`, and gives read data on `int_rdata` in the same cycle.

Top module: `host_bus_if`

## Requirements
- R1: After reset, `bus_rdy` is 1, `loc_done_n` is 1, all four internal strobes are 0, the block is in strobe mode and the buffer pointer is 0.
- R2: The effective address follows `addr` while `addr_stb_n` is 0 and holds the value present at its rising edge; later changes of `addr` do not affect the access.
- R3: In strobe mode, `bus_rdy` goes to 0 in the same time step that `rd_stb_n` or `wr_stb_n` falls, with no clock edge needed.
- R4: In strobe mode, `bus_rdy` stays 0 for the first two clock edges after `int_done` is sampled high and returns to 1 after the third; read data on `bus_rdata` is valid once `bus_rdy` is 1.
- R5: In clocked mode an access starts when `cyc_start_n` is 0 at a clock edge, with `bus_write` = 1 meaning write. `loc_done_n` is 0 for exactly one clock, on the clock after the edge that samples `int_done`, and `bus_rdata` is valid then.
- R6: In clocked mode `bus_rdy` stays 1 and the read and write strobes have no effect. In strobe mode `loc_done_n` stays 1.
- R7: `mode_sync` (1 = clocked, 0 = strobe) is taken in only while no access is in progress. A change during an access leaves that access in its old mode.
- R8: With `dma_sel_n` = 0 the access goes to the buffer port (`dp_rd`/`dp_wr`, address `dp_addr` = pointer) whatever the address is. Register strobes are not raised. At most one internal strobe is high at any time.
- R9: Each completed DMA transfer adds 4 to the pointer.
- R10: A DMA access whose `lanes` is not 4'b1111 raises no internal strobe and leaves the pointer unchanged. It still completes on the bus, and a read returns 0.
- R11: A non-DMA write to address `PTR_ADDR` loads the pointer from write data with bits [1:0] cleared, and a read there returns the pointer. Neither raises a register strobe.
- R12: A register access presents its held address, write data and byte lanes (bit i enables byte i) on `reg_addr`, `int_wdata` and `int_lanes`, with a strobe lasting one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; in clocked mode also the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sync | input | 1 | 1 = clocked bus mode, 0 = strobe mode |
| addr_stb_n | input | 1 | Address strobe, transparent while low |
| addr | input | AW | Host address |
| lanes | input | 4 | Byte lanes, bit i enables byte i |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data to host |
| rd_stb_n | input | 1 | Strobe-mode read strobe |
| wr_stb_n | input | 1 | Strobe-mode write strobe |
| bus_rdy | output | 1 | Strobe-mode ready, 0 extends the cycle |
| cyc_start_n | input | 1 | Clocked-mode cycle start |
| bus_write | input | 1 | Clocked-mode direction, 1 = write |
| loc_done_n | output | 1 | Clocked-mode completion pulse |
| dma_sel_n | input | 1 | DMA select, skips the address decode |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | AW | Register address |
| dp_rd | output | 1 | Buffer port read strobe |
| dp_wr | output | 1 | Buffer port write strobe |
| dp_addr | output | PTR_W | Buffer port byte address |
| int_wdata | output | 32 | Write data to internal side |
| int_lanes | output | 4 | Byte lanes to internal side |
| int_rdata | input | 32 | Read data from internal side |
| int_done | input | 1 | Internal completion pulse |

## Verification
The bench checks the cycle counts of the completion paths. A design that skipped the two-flop completion stage would release `bus_rdy` two clocks early. One that stretched or delayed the done pulse would show `loc_done_n` wrong at the sampled clocks. The address bus is scrambled after the address strobe rises and the DMA accesses carry unrelated addresses, so a design that decodes the live address or ignores the bypass sends a strobe with the wrong address. Partial-lane DMA accesses, pointer load and readback, and a mode flip in the middle of a clocked access target a pointer that steps at the wrong time, a missing rejection, and a mode change taken while busy, which would lose the done pulse.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int DW         = 32;
  localparam int LANE_W     = DW / 8;
  localparam int WORD_BYTES = LANE_W;
  localparam logic [LANE_W-1:0] LANES_ALL = '1;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WAIT = 2'd1,
    XS_FIN  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/hbi_addr_hold.sv
module hbi_addr_hold #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          addr_stb_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_eff
);
  logic [AW-1:0] addr_q, addr_n;

  always_comb begin
    addr_n = addr_q;
    if (!addr_stb_n) addr_n = addr_in;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_n;
  end

  assign addr_eff = addr_stb_n ? addr_q : addr_in;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    addr_stb_n |=> (addr_q == $past(addr_q)));
endmodule

// File: rtl/hbi_async_fe.sv
module hbi_async_fe (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic rd_stb_n,
  input  logic wr_stb_n,
  input  logic done,
  output logic start,
  output logic start_wr,
  output logic busy,
  output logic bus_rdy
);
  logic [1:0] rd_sync_q, wr_sync_q;
  logic       rd_d_q, wr_d_q, flag_q, flag_n;
  logic       rd_s, wr_s, rd_rise, wr_rise;

  assign rd_s    = rd_sync_q[1];
  assign wr_s    = wr_sync_q[1];
  assign rd_rise = rd_s & ~rd_d_q;
  assign wr_rise = wr_s & ~wr_d_q;

  always_comb begin
    flag_n = flag_q;
    if (done && en) flag_n = 1'b1;
    else if (!rd_s && !wr_s && !rd_sync_q[0] && !wr_sync_q[0]) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sync_q <= '0;
      wr_sync_q <= '0;
      rd_d_q    <= 1'b0;
      wr_d_q    <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      rd_sync_q <= {rd_sync_q[0], ~rd_stb_n};
      wr_sync_q <= {wr_sync_q[0], ~wr_stb_n};
      rd_d_q    <= rd_s;
      wr_d_q    <= wr_s;
      flag_q    <= flag_n;
    end
  end

  assign start    = en & ~flag_q & (rd_rise | wr_rise);
  assign start_wr = wr_rise;
  assign busy     = (|rd_sync_q) | (|wr_sync_q) | rd_d_q | wr_d_q | flag_q;
  // leading edge from the raw strobe, trailing edge from the clocked flag
  assign bus_rdy  = ~en | ~((~rd_stb_n | ~wr_stb_n) & ~flag_q);

  // R4
  rdy_after_done_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(done));
endmodule

// File: rtl/hbi_xfer_core.sv
module hbi_xfer_core
  import hbi_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PTR_W    = 16,
  parameter int PTR_ADDR = 'h3C
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              async_mode,
  input  logic              start,
  input  logic              s_wr,
  input  logic              s_dcs,
  input  logic [AW-1:0]     s_addr,
  input  logic [LANE_W-1:0] s_lanes,
  input  logic [DW-1:0]     s_wdata,
  input  logic              int_done,
  input  logic [DW-1:0]     int_rdata,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic              dp_rd,
  output logic              dp_wr,
  output logic [AW-1:0]     reg_addr,
  output logic [PTR_W-1:0]  dp_addr,
  output logic [DW-1:0]     int_wdata,
  output logic [LANE_W-1:0] int_lanes,
  output logic [DW-1:0]     rdata,
  output logic              done,
  output logic              idle
);
  typedef struct packed {
    logic              wr;
    logic              dcs;
    logic [AW-1:0]     addr;
    logic [LANE_W-1:0] lanes;
    logic [DW-1:0]     wdata;
  } req_t;

  localparam logic [AW-1:0] PTR_SEL = AW'(PTR_ADDR);

  xfer_state_e      st_q, st_n;
  req_t             req_q, req_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [DW-1:0]    rdat_q, rdat_n;
  logic [3:0]       stb_q, stb_n;
  logic [1:0]       ack_s_q;
  logic             ack_eff;

  assign ack_eff = async_mode ? ack_s_q[1] : int_done;

  always_comb begin
    st_n   = st_q;
    req_n  = req_q;
    ptr_n  = ptr_q;
    rdat_n = rdat_q;
    stb_n  = '0;
    done   = 1'b0;
    case (st_q)
      XS_IDLE: begin
        if (start) begin
          req_n = '{wr: s_wr, dcs: s_dcs, addr: s_addr, lanes: s_lanes, wdata: s_wdata};
          if (s_dcs && (s_lanes != LANES_ALL)) begin
            st_n = XS_FIN;
            if (!s_wr) rdat_n = '0;
          end else if (!s_dcs && (s_addr == PTR_SEL)) begin
            st_n = XS_FIN;
            if (s_wr) ptr_n  = {s_wdata[PTR_W-1:2], 2'b00};
            else      rdat_n = DW'(ptr_q);
          end else begin
            st_n  = XS_WAIT;
            stb_n = s_dcs ? (s_wr ? 4'b1000 : 4'b0100)
                          : (s_wr ? 4'b0010 : 4'b0001);
          end
        end
      end
      XS_WAIT: begin
        if (int_done && !req_q.wr) rdat_n = int_rdata;
        if (ack_eff) begin
          done = 1'b1;
          st_n = XS_IDLE;
          if (req_q.dcs) ptr_n = ptr_q + PTR_W'(WORD_BYTES);
        end
      end
      XS_FIN: begin
        done = 1'b1;
        st_n = XS_IDLE;
      end
      default: st_n = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= XS_IDLE;
      req_q   <= '0;
      ptr_q   <= '0;
      rdat_q  <= '0;
      stb_q   <= '0;
      ack_s_q <= '0;
    end else begin
      st_q    <= st_n;
      req_q   <= req_n;
      ptr_q   <= ptr_n;
      rdat_q  <= rdat_n;
      stb_q   <= stb_n;
      ack_s_q <= {ack_s_q[0], int_done};
    end
  end

  assign {dp_wr, dp_rd, reg_wr, reg_rd} = stb_q;
  assign reg_addr  = req_q.addr;
  assign dp_addr   = ptr_q;
  assign int_wdata = req_q.wdata;
  assign int_lanes = req_q.lanes;
  assign rdata     = rdat_q;
  assign idle      = (st_q == XS_IDLE);

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(stb_q));

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == XS_WAIT && ack_eff && req_q.dcs) |=> (ptr_q == $past(ptr_q) + PTR_W'(WORD_BYTES)));

  // R10
  partial_dma_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == XS_IDLE && start && s_dcs && s_lanes != LANES_ALL) |=> (stb_q == '0 && ptr_q == $past(ptr_q)));

  // R11
  ptr_reg_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == XS_IDLE && start && !s_dcs && s_addr == PTR_SEL) |=> (stb_q == '0));
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import hbi_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PTR_W    = 16,
  parameter int PTR_ADDR = 'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic              addr_stb_n,
  input  logic [AW-1:0]     addr,
  input  logic [3:0]        lanes,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rd_stb_n,
  input  logic              wr_stb_n,
  output logic              bus_rdy,
  input  logic              cyc_start_n,
  input  logic              bus_write,
  output logic              loc_done_n,
  input  logic              dma_sel_n,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [AW-1:0]     reg_addr,
  output logic              dp_rd,
  output logic              dp_wr,
  output logic [PTR_W-1:0]  dp_addr,
  output logic [31:0]       int_wdata,
  output logic [3:0]        int_lanes,
  input  logic [31:0]       int_rdata,
  input  logic              int_done
);
  logic          rst_meta_q, rst_ni;
  logic          mode_q, mode_n;
  logic          srdy_q, srdy_n;
  logic [AW-1:0] addr_eff;
  logic          fe_start, fe_start_wr, fe_busy;
  logic          core_done, core_idle;
  logic          a_start, s_start, start, s_wr, bus_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_ni, rst_meta_q} <= 2'b00;
    else        {rst_ni, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  hbi_addr_hold #(.AW(AW)) u_addr (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .addr_stb_n (addr_stb_n),
    .addr_in    (addr),
    .addr_eff   (addr_eff)
  );

  hbi_async_fe u_afe (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .en       (~mode_q),
    .rd_stb_n (rd_stb_n),
    .wr_stb_n (wr_stb_n),
    .done     (core_done),
    .start    (fe_start),
    .start_wr (fe_start_wr),
    .busy     (fe_busy),
    .bus_rdy  (bus_rdy)
  );

  assign a_start  = fe_start & core_idle;
  assign s_start  = mode_q & ~cyc_start_n & core_idle & ~srdy_q;
  assign start    = a_start | s_start;
  assign s_wr     = mode_q ? bus_write : fe_start_wr;
  assign bus_idle = core_idle & ~fe_busy & rd_stb_n & wr_stb_n & cyc_start_n & ~srdy_q;

  hbi_xfer_core #(.AW(AW), .PTR_W(PTR_W), .PTR_ADDR(PTR_ADDR)) u_core (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .async_mode (~mode_q),
    .start      (start),
    .s_wr       (s_wr),
    .s_dcs      (~dma_sel_n),
    .s_addr     (addr_eff),
    .s_lanes    (lanes),
    .s_wdata    (bus_wdata),
    .int_done   (int_done),
    .int_rdata  (int_rdata),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .dp_rd      (dp_rd),
    .dp_wr      (dp_wr),
    .reg_addr   (reg_addr),
    .dp_addr    (dp_addr),
    .int_wdata  (int_wdata),
    .int_lanes  (int_lanes),
    .rdata      (bus_rdata),
    .done       (core_done),
    .idle       (core_idle)
  );

  always_comb begin
    mode_n = mode_q;
    if (bus_idle) mode_n = mode_sync;
    srdy_n = mode_q & core_done;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      srdy_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      srdy_q <= srdy_n;
    end
  end

  assign loc_done_n = ~srdy_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !loc_done_n |=> loc_done_n);

  // R6
  rdy_clocked_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mode_q |-> bus_rdy);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_idle |=> (mode_q == $past(mode_q)));
endmodule

// File: tb/sim_host_bus_if.sv
module sim_host_bus_if;
  localparam int AW = 8;
  localparam int PTR_W = 16;
  localparam logic [7:0] PA = 8'h3C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mode_sync, addr_stb_n, rd_stb_n, wr_stb_n, cyc_start_n, bus_write, dma_sel_n;
  logic [AW-1:0] addr;
  logic [3:0] lanes, int_lanes;
  logic [31:0] bus_wdata, bus_rdata, int_wdata, int_rdata;
  logic bus_rdy, loc_done_n, reg_rd, reg_wr, dp_rd, dp_wr, int_done;
  logic [AW-1:0] reg_addr;
  logic [PTR_W-1:0] dp_addr;

  host_bus_if #(.AW(AW), .PTR_W(PTR_W), .PTR_ADDR('h3C)) u0 (.*);

  typedef struct {int kind; logic [31:0] a; logic [31:0] d; logic [3:0] ln;} item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit tb_async = 1'b1;
  bit ended = 1'b0;

  function automatic logic [31:0] rdfn(input logic [31:0] a);
    return 32'hC0DE_0000 ^ a;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor + internal-side responder
  initial begin
    int_done = 1'b0;
    int_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && (reg_rd || reg_wr || dp_rd || dp_wr)) begin
        int k;
        logic [31:0] a;
        k = reg_rd ? 0 : reg_wr ? 1 : dp_rd ? 2 : 3;
        a = (k < 2) ? 32'(reg_addr) : 32'(dp_addr);
        if (q.size() == 0) begin
          chk("R8", "unexpected strobe kind", 32'(k), 32'hFFFF_FFFF);
        end else begin
          item_t e;
          e = q.pop_front();
          chk("R8", "strobe kind", 32'(k), 32'(e.kind));
          chk("R12", "internal address", a, e.a);
          if (k == 1 || k == 3) begin
            chk("R12", "write data", int_wdata, e.d);
            chk("R12", "byte lanes", 32'(int_lanes), 32'(e.ln));
          end
        end
        repeat (2) @(negedge clk);
        int_rdata = rdfn(a);
        int_done = 1'b1;
        @(negedge clk);
        int_done = 1'b0;
        if (tb_async) begin
          chk("R4", "ready one edge after done", 32'(bus_rdy), 32'd0);
          @(negedge clk);
          chk("R4", "ready two edges after done", 32'(bus_rdy), 32'd0);
          @(negedge clk);
          chk("R4", "ready three edges after done", 32'(bus_rdy), 32'd1);
          chk("R6", "clocked done idle in strobe mode", 32'(loc_done_n), 32'd1);
        end else begin
          chk("R5", "done pulse low", 32'(loc_done_n), 32'd0);
          if (k == 0 || k == 2) chk("R5", "read data at done", bus_rdata, rdfn(a));
          @(negedge clk);
          chk("R5", "done pulse one clock", 32'(loc_done_n), 32'd1);
          chk("R6", "ready high in clocked mode", 32'(bus_rdy), 32'd1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: act=expired exp=finished");
    finish_up();
  end

  task automatic push(input int k, input logic [31:0] a, input logic [31:0] d, input logic [3:0] ln);
    item_t e;
    e.kind = k; e.a = a; e.d = d; e.ln = ln;
    q.push_back(e);
  endtask

  task automatic acc_async(input bit wr, input logic [7:0] a, input bit dcs, input logic [3:0] ln,
                           input logic [31:0] wd, input logic [31:0] erd, input string tag);
    int n;
    @(negedge clk);
    addr_stb_n = 1'b0; addr = a; lanes = ln; bus_wdata = wd; dma_sel_n = ~dcs;
    @(negedge clk);
    addr_stb_n = 1'b1; addr = ~a;
    if (wr) wr_stb_n = 1'b0; else rd_stb_n = 1'b0;
    #1;
    chk("R3", "ready drops with strobe", 32'(bus_rdy), 32'd0);
    n = 0;
    while (!bus_rdy && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(tag, "access completes", 32'(bus_rdy), 32'd1);
    if (!wr) chk(tag, "read data", bus_rdata, erd);
    @(negedge clk);
    rd_stb_n = 1'b1; wr_stb_n = 1'b1; dma_sel_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic acc_sync(input bit wr, input logic [7:0] a, input bit dcs, input logic [3:0] ln,
                          input logic [31:0] wd, input logic [31:0] erd, input string tag);
    int n;
    @(negedge clk);
    addr_stb_n = 1'b0; addr = a; cyc_start_n = 1'b0; bus_write = wr;
    lanes = ln; bus_wdata = wd; dma_sel_n = ~dcs;
    @(negedge clk);
    addr_stb_n = 1'b1; cyc_start_n = 1'b1; addr = ~a; dma_sel_n = 1'b1;
    n = 0;
    while (loc_done_n && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(tag, "clocked access completes", 32'(loc_done_n), 32'd0);
    if (!wr) chk(tag, "clocked read data", bus_rdata, erd);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mode_sync = 1'b0; addr_stb_n = 1'b1; rd_stb_n = 1'b1; wr_stb_n = 1'b1;
    cyc_start_n = 1'b1; bus_write = 1'b0; dma_sel_n = 1'b1; addr = '0; lanes = 4'hF; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "ready after reset", 32'(bus_rdy), 32'd1);
    chk("R1", "done idle after reset", 32'(loc_done_n), 32'd1);
    chk("R1", "strobes after reset", 32'({reg_rd, reg_wr, dp_rd, dp_wr}), 32'd0);
    acc_async(1'b0, PA, 1'b0, 4'hF, '0, 32'h0, "R1");
    // strobe-mode register accesses
    push(0, 32'h10, '0, 4'hF);
    acc_async(1'b0, 8'h10, 1'b0, 4'hF, '0, rdfn(32'h10), "R2");
    push(1, 32'h22, 32'h1234_5678, 4'b0011);
    acc_async(1'b1, 8'h22, 1'b0, 4'b0011, 32'h1234_5678, '0, "R12");
    // pointer load and readback
    acc_async(1'b1, PA, 1'b0, 4'hF, 32'h0000_1237, '0, "R11");
    acc_async(1'b0, PA, 1'b0, 4'hF, '0, 32'h1234, "R11");
    // DMA bypass
    push(2, 32'h1234, '0, 4'hF);
    acc_async(1'b0, 8'h05, 1'b1, 4'hF, '0, rdfn(32'h1234), "R8");
    push(3, 32'h1238, 32'hDEAD_BEEF, 4'hF);
    acc_async(1'b1, 8'h10, 1'b1, 4'hF, 32'hDEAD_BEEF, '0, "R9");
    acc_async(1'b0, PA, 1'b0, 4'hF, '0, 32'h123C, "R9");
    // partial-lane DMA rejected
    acc_async(1'b0, 8'h05, 1'b1, 4'b0111, '0, 32'h0, "R10");
    acc_async(1'b0, PA, 1'b0, 4'hF, '0, 32'h123C, "R10");
    // switch to clocked mode
    mode_sync = 1'b1;
    repeat (3) @(negedge clk);
    tb_async = 1'b0;
    rd_stb_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6", "read strobe ignored in clocked mode", 32'(bus_rdy), 32'd1);
    rd_stb_n = 1'b1;
    repeat (4) @(negedge clk);
    push(0, 32'h31, '0, 4'hF);
    acc_sync(1'b0, 8'h31, 1'b0, 4'hF, '0, rdfn(32'h31), "R5");
    push(1, 32'h07, 32'hA0B1_C2D3, 4'b1100);
    acc_sync(1'b1, 8'h07, 1'b0, 4'b1100, 32'hA0B1_C2D3, '0, "R12");
    push(3, 32'h123C, 32'h0F0F_0F0F, 4'hF);
    acc_sync(1'b1, 8'h20, 1'b1, 4'hF, 32'h0F0F_0F0F, '0, "R8");
    push(2, 32'h1240, '0, 4'hF);
    acc_sync(1'b0, 8'h21, 1'b1, 4'hF, '0, rdfn(32'h1240), "R9");
    acc_sync(1'b0, PA, 1'b0, 4'hF, '0, 32'h1244, "R9");
    acc_sync(1'b1, 8'h21, 1'b1, 4'b1110, 32'h5555_5555, '0, "R10");
    acc_sync(1'b0, PA, 1'b0, 4'hF, '0, 32'h1244, "R10");
    // R7 mode change during an access
    push(0, 32'h44, '0, 4'hF);
    fork
      acc_sync(1'b0, 8'h44, 1'b0, 4'hF, '0, rdfn(32'h44), "R7");
      begin
        repeat (2) @(negedge clk);
        mode_sync = 1'b0;
      end
    join
    tb_async = 1'b1;
    repeat (3) @(negedge clk);
    push(0, 32'h50, '0, 4'hF);
    acc_async(1'b0, 8'h50, 1'b0, 4'hF, '0, rdfn(32'h50), "R7");
    repeat (4) @(negedge clk);
    chk("R8", "scoreboard drained", 32'(q.size()), 32'd0);
    finish_up();
  end
endmodule